// File: doc/BRIEF.md
# Isochronous Frame-Synchronized Prime Scheduler

This block lets software schedule one isochronous endpoint so that its packet goes out in a chosen microframe. Software posts a prime request that carries a target frame number. The block then watches the running 11-bit frame index. In the frame just before the target it asks the descriptor fetch logic to prime the endpoint, and the endpoint becomes armed once the fetch logic reports completion.

A prime that finishes before the start-of-frame (SOF) of the target frame delivers in the target frame. If an SOF arrives first, delivery moves to the following frame. The block records the frame in which delivery actually took place.

The block also answers tokens addressed to the endpoint, using its state and a stall input. After a packet is delivered the descriptor retires. If another prime request was posted while the endpoint was busy, the next descriptor is primed for the frame that immediately follows.

The controller has five states:
- `ST_IDLE`: waiting for a request.
- `ST_WAIT_ARM`: waiting for the frame before the target.
- `ST_FETCH`: the prime is in progress.
- `ST_ARMED`: primed, but the delivery frame has not started.
- `ST_ACTIVE`: primed, and the delivery frame has been reached.

The transitions are:
- request-accept: `ST_IDLE` to `ST_WAIT_ARM`, or directly to `ST_FETCH` when the effective target is the next frame.
- arm-hit: `ST_WAIT_ARM` to `ST_FETCH`.
- prime-done: `ST_FETCH` to `ST_ARMED`.
- frame-due: `ST_ARMED` to `ST_ACTIVE`.
- retire: `ST_ARMED` or `ST_ACTIVE` to `ST_IDLE`.
- chain: `ST_ARMED` or `ST_ACTIVE` to `ST_FETCH`.

Top module: `iso_prime_sched`

## Requirements
- R1: After reset, `primed`, `fetch_req`, `resp_valid` and `deliv_valid` are all 0.
- R2: While a request waits, `fetch_req` stays 0 until the frame index equals target−1 (modulo 2048). It is 1 from the clock edge that sees that match, and it stays 1 until `fetch_done`.
- R3: A `fetch_done` with no SOF during the fetch sets `primed` on the next edge, and the packet is delivered in the target frame.
- R4: Each SOF seen during the fetch pushes delivery one frame later. An SOF in the same cycle as `fetch_done` counts as arriving first.
- R5: A target equal to the current frame index is treated as the next frame. The fetch starts on the edge after the request.
- R6: A SETUP token (`token_type` 2'b10) is answered with STALL (`resp_code` 2'b01) in every state and with any stall setting.
- R7: An IN token (`token_type` 2'b01) is answered with a packet (`resp_code` 2'b11) only if the endpoint is primed and the frame index has reached the delivery frame. Otherwise an unstalled IN token is answered with a zero-length packet (`resp_code` 2'b10).
- R8: While `ep_stall` is 1, an IN token is answered with STALL, nothing is delivered, and `primed` keeps its value.
- R9: An OUT token (2'b00) or code 2'b11 gets `resp_code` 2'b00 (no response). Every token's response appears one cycle after it, with `resp_valid` set.
- R10: A delivery retires the descriptor and clears `primed`. If a prime request was posted since the request in service, the next fetch starts at once for the frame after the delivery frame, and that request's target is ignored.
- R11: Frame comparisons wrap: a target of 0 is armed at frame 2047 and delivered at frame 0.
- R12: Each delivery pulses `deliv_valid` together with the packet response. `deliv_frame` carries the frame index in effect when the IN token arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_idx | input | 11 | Running frame index, already updated in the SOF cycle |
| sof | input | 1 | One-cycle start-of-frame strobe |
| prime_req | input | 1 | Software prime request |
| prime_target | input | 11 | Requested delivery frame |
| fetch_done | input | 1 | Descriptor fetch reports the prime complete |
| ep_stall | input | 1 | Endpoint stall setting |
| token_valid | input | 1 | A token for this endpoint is present |
| token_type | input | 2 | 00 OUT, 01 IN, 10 SETUP |
| fetch_req | output | 1 | Prime request to the descriptor fetch |
| primed | output | 1 | Endpoint is primed |
| resp_valid | output | 1 | Response code is valid |
| resp_code | output | 2 | 00 none, 01 STALL, 10 zero-length, 11 packet |
| deliv_valid | output | 1 | A packet was delivered |
| deliv_frame | output | 11 | Frame of the latest delivery |

## Verification
A controller stuck in `ST_ARMED` or moved to `ST_ACTIVE` too early shows up at the very next IN token: the bench expects a zero-length answer where a packet comes back, or the reverse. A slip counter that is off by one shows up as a packet in the wrong frame, seen on `deliv_frame` one cycle after the IN token. An arm comparison that is off by one, or that does not wrap, shows up as `fetch_req` rising one frame early or late, which the bench samples on the cycle right after the SOF. A lost pending request shows up as `fetch_req` staying low on the cycle after a chained delivery.

// File: rtl/iso_sched_pkg.sv
package iso_sched_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_ARM,
        ST_FETCH,
        ST_ARMED,
        ST_ACTIVE
    } sched_state_e;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'b00,
        TOK_IN    = 2'b01,
        TOK_SETUP = 2'b10
    } token_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'b00,
        RSP_STALL = 2'b01,
        RSP_ZLP   = 2'b10,
        RSP_DATA  = 2'b11
    } resp_e;
endpackage

// File: rtl/iso_frame_cmp.sv
module iso_frame_cmp #(
    parameter int FW = 11
) (
    input  logic [FW-1:0] cur_frame,
    input  logic [FW-1:0] req_target,
    input  logic [FW-1:0] arm_target,
    input  logic [FW-1:0] sched_frame,
    output logic [FW-1:0] next_frame,
    output logic [FW-1:0] eff_target,
    output logic          eff_is_next,
    output logic          arm_hit,
    output logic          due_hit
);
    localparam logic [FW-1:0] ONE = FW'(1);

    logic [FW-1:0] prev_of_arm;

    always_comb begin
        next_frame  = cur_frame + ONE;
        prev_of_arm = arm_target - ONE;
        // a target equal to the running frame slips to the next frame
        eff_target  = (req_target == cur_frame) ? next_frame : req_target;
        eff_is_next = (eff_target == next_frame);
        arm_hit     = (cur_frame == prev_of_arm);
        due_hit     = (cur_frame == sched_frame);
    end
endmodule

// File: rtl/iso_resp_enc.sv
module iso_resp_enc
    import iso_sched_pkg::*;
(
    input  logic [1:0] tok_type,
    input  logic       stalled,
    input  logic       due,
    output logic [1:0] code
);
    always_comb begin
        unique case (tok_type)
            TOK_SETUP: code = RSP_STALL;
            TOK_IN:    code = stalled ? RSP_STALL : (due ? RSP_DATA : RSP_ZLP);
            default:   code = RSP_NONE;
        endcase
    end
endmodule

// File: rtl/iso_prime_sched.sv
module iso_prime_sched
    import iso_sched_pkg::*;
#(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_idx,
    input  logic               sof,
    input  logic               prime_req,
    input  logic [FRAME_W-1:0] prime_target,
    input  logic               fetch_done,
    input  logic               ep_stall,
    input  logic               token_valid,
    input  logic [1:0]         token_type,
    output logic               fetch_req,
    output logic               primed,
    output logic               resp_valid,
    output logic [1:0]         resp_code,
    output logic               deliv_valid,
    output logic [FRAME_W-1:0] deliv_frame
);
    localparam logic [FRAME_W-1:0] ONE = FRAME_W'(1);

    sched_state_e       state_q, state_d;
    logic [FRAME_W-1:0] target_q, target_d;
    logic [FRAME_W-1:0] sched_q, sched_d;
    logic               pend_q, pend_d;

    logic [FRAME_W-1:0] next_frame, eff_target;
    logic               eff_is_next, arm_hit, due_hit;
    logic               due, deliver, pend_set;
    logic [1:0]         enc_code;

    iso_frame_cmp #(.FW(FRAME_W)) u_cmp (
        .cur_frame   (frame_idx),
        .req_target  (prime_target),
        .arm_target  (target_q),
        .sched_frame (sched_q),
        .next_frame  (next_frame),
        .eff_target  (eff_target),
        .eff_is_next (eff_is_next),
        .arm_hit     (arm_hit),
        .due_hit     (due_hit)
    );

    assign due = (state_q == ST_ACTIVE) || ((state_q == ST_ARMED) && due_hit);

    iso_resp_enc u_enc (
        .tok_type (token_type),
        .stalled  (ep_stall),
        .due      (due),
        .code     (enc_code)
    );

    assign deliver  = token_valid && (token_type == TOK_IN) && !ep_stall && due;
    assign pend_set = prime_req && (state_q != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d  = state_q;
        target_d = target_q;
        sched_d  = sched_q;
        pend_d   = pend_q || pend_set;
        unique case (state_q)
            ST_IDLE: begin
                if (prime_req) begin
                    target_d = eff_target;
                    if (eff_is_next) begin
                        state_d = ST_FETCH;
                        sched_d = eff_target;
                    end else begin
                        state_d = ST_WAIT_ARM;
                    end
                end
            end
            ST_WAIT_ARM: begin
                if (arm_hit) begin
                    state_d = ST_FETCH;
                    sched_d = target_q;
                end
            end
            ST_FETCH: begin
                if (sof) begin
                    sched_d = sched_q + ONE;
                end
                if (fetch_done) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (due_hit) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                state_d = ST_ACTIVE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (deliver) begin
            if (pend_q || pend_set) begin
                state_d = ST_FETCH;
                sched_d = next_frame;
                pend_d  = 1'b0;
            end else begin
                state_d = ST_IDLE;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            target_q <= '0;
            sched_q  <= '0;
            pend_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            target_q <= target_d;
            sched_q  <= sched_d;
            pend_q   <= pend_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_code   <= RSP_NONE;
            deliv_valid <= 1'b0;
            deliv_frame <= '0;
        end else begin
            resp_valid  <= token_valid;
            resp_code   <= token_valid ? enc_code : RSP_NONE;
            deliv_valid <= deliver;
            if (deliver) begin
                deliv_frame <= frame_idx;
            end
        end
    end

    assign fetch_req = (state_q == ST_FETCH);
    assign primed    = (state_q == ST_ARMED) || (state_q == ST_ACTIVE);
endmodule

// File: rtl/iso_prime_sched_chk.sv
module iso_prime_sched_chk #(
    parameter int FRAME_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sof,
    input logic               fetch_done,
    input logic               ep_stall,
    input logic               token_valid,
    input logic [1:0]         token_type,
    input logic               fetch_req,
    input logic               primed,
    input logic               resp_valid,
    input logic [1:0]         resp_code,
    input logic               deliv_valid,
    input logic [FRAME_W-1:0] deliv_frame
);
    // R2
    fetch_not_primed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> !primed);

    // R3
    prime_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed) |-> $past(fetch_done) && $past(fetch_req));

    // R6
    setup_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (token_valid && token_type == 2'b10) |=> (resp_valid && resp_code == 2'b01));

    // R8
    stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (token_valid && token_type == 2'b01 && ep_stall) |=>
            (resp_code == 2'b01 && !deliv_valid && primed == $past(primed)));

    // R9
    out_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (token_valid && token_type == 2'b00) |=> (resp_valid && resp_code == 2'b00));

    // R12
    deliv_pairs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deliv_valid |-> (resp_valid && resp_code == 2'b11 && $past(primed)));

    // R10
    deliv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deliv_valid |-> !primed);
endmodule

bind iso_prime_sched iso_prime_sched_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof         (sof),
    .fetch_done  (fetch_done),
    .ep_stall    (ep_stall),
    .token_valid (token_valid),
    .token_type  (token_type),
    .fetch_req   (fetch_req),
    .primed      (primed),
    .resp_valid  (resp_valid),
    .resp_code   (resp_code),
    .deliv_valid (deliv_valid),
    .deliv_frame (deliv_frame)
);

// File: tb/iso_prime_sched_tb_top.sv
module iso_prime_sched_tb_top;
    localparam int FW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] frame_idx = '0;
    logic          sof = 1'b0;
    logic          prime_req = 1'b0;
    logic [FW-1:0] prime_target = '0;
    logic          fetch_done = 1'b0;
    logic          ep_stall = 1'b0;
    logic          token_valid = 1'b0;
    logic [1:0]    token_type = 2'b00;
    logic          fetch_req, primed, resp_valid, deliv_valid;
    logic [1:0]    resp_code;
    logic [FW-1:0] deliv_frame;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        int    code;
        int    frame;
        string req;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    iso_prime_sched #(.FRAME_W(FW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_idx    (frame_idx),
        .sof          (sof),
        .prime_req    (prime_req),
        .prime_target (prime_target),
        .fetch_done   (fetch_done),
        .ep_stall     (ep_stall),
        .token_valid  (token_valid),
        .token_type   (token_type),
        .fetch_req    (fetch_req),
        .primed       (primed),
        .resp_valid   (resp_valid),
        .resp_code    (resp_code),
        .deliv_valid  (deliv_valid),
        .deliv_frame  (deliv_frame)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_frame(input int f);
        frame_idx = FW'(f);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
    endtask

    task automatic prime(input int t);
        prime_req = 1'b1;
        prime_target = FW'(t);
        @(negedge clk);
        prime_req = 1'b0;
    endtask

    task automatic done_pulse();
        fetch_done = 1'b1;
        @(negedge clk);
        fetch_done = 1'b0;
    endtask

    // driver: push the expected response, then present the token
    task automatic token(input int ty, input int code, input int frame, input string req);
        exp_t e;
        e.code = code;
        e.frame = frame;
        e.req = req;
        exp_q.push_back(e);
        token_valid = 1'b1;
        token_type = 2'(ty);
        @(negedge clk);
        token_valid = 1'b0;
    endtask

    // monitor: pop and compare each response as it appears
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected response", int'(resp_code), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(resp_code) == e.code, e.req, "resp_code", int'(resp_code), e.code);
                check(deliv_valid == (e.code == 3), e.req, "deliv_valid",
                      int'(deliv_valid), int'(e.code == 3));
                if (e.code == 3) begin
                    check(int'(deliv_frame) == e.frame, e.req, "deliv_frame",
                          int'(deliv_frame), e.frame);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(primed == 1'b0, "R1", "primed", int'(primed), 0);
        check(fetch_req == 1'b0, "R1", "fetch_req", int'(fetch_req), 0);
        check(resp_valid == 1'b0, "R1", "resp_valid", int'(resp_valid), 0);
        check(deliv_valid == 1'b0, "R1", "deliv_valid", int'(deliv_valid), 0);

        // unprimed endpoint: R7 zero-length, R6 stall, R9 none
        token(1, 2, 0, "R7");
        token(2, 1, 0, "R6");
        token(0, 0, 0, "R9");
        token(3, 0, 0, "R9");

        // R2/R3: on-time prime
        set_frame(100);
        prime(105);
        set_frame(101);
        set_frame(102);
        set_frame(103);
        check(fetch_req == 1'b0, "R2", "fetch_req early", int'(fetch_req), 0);
        set_frame(104);
        check(fetch_req == 1'b1, "R2", "fetch_req at N-1", int'(fetch_req), 1);
        token(1, 2, 0, "R7");
        done_pulse();
        check(primed == 1'b1, "R3", "primed", int'(primed), 1);
        token(1, 2, 0, "R7");
        token(2, 1, 0, "R6");
        set_frame(105);
        token(1, 3, 105, "R3");
        check(primed == 1'b0, "R10", "primed after retire", int'(primed), 0);

        // R4: SOF during the fetch
        set_frame(200);
        prime(202);
        set_frame(201);
        check(fetch_req == 1'b1, "R2", "fetch_req", int'(fetch_req), 1);
        set_frame(202);
        done_pulse();
        token(1, 2, 0, "R4");
        set_frame(203);
        token(1, 3, 203, "R4");

        // R4: SOF and fetch_done in the same cycle
        set_frame(300);
        prime(301);
        frame_idx = FW'(301);
        sof = 1'b1;
        fetch_done = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        fetch_done = 1'b0;
        token(1, 2, 0, "R4");
        set_frame(302);
        token(1, 3, 302, "R4");

        // R5: target equals current frame
        set_frame(400);
        prime(400);
        check(fetch_req == 1'b1, "R5", "fetch_req", int'(fetch_req), 1);
        done_pulse();
        set_frame(401);
        token(1, 3, 401, "R5");

        // R8: stall
        set_frame(500);
        prime(501);
        done_pulse();
        set_frame(501);
        ep_stall = 1'b1;
        token(1, 1, 0, "R8");
        token(2, 1, 0, "R6");
        check(primed == 1'b1, "R8", "primed kept", int'(primed), 1);
        ep_stall = 1'b0;
        token(1, 3, 501, "R8");

        // R10: chained descriptor
        set_frame(600);
        prime(601);
        done_pulse();
        prime(700);
        set_frame(601);
        token(1, 3, 601, "R10");
        check(fetch_req == 1'b1, "R10", "chained fetch_req", int'(fetch_req), 1);
        done_pulse();
        check(primed == 1'b1, "R10", "chained primed", int'(primed), 1);
        token(1, 2, 0, "R10");
        set_frame(602);
        token(1, 3, 602, "R10");

        // R11: wrap
        set_frame(2046);
        prime(0);
        check(fetch_req == 1'b0, "R11", "fetch_req before wrap", int'(fetch_req), 0);
        set_frame(2047);
        check(fetch_req == 1'b1, "R11", "fetch_req at 2047", int'(fetch_req), 1);
        done_pulse();
        set_frame(0);
        token(1, 3, 0, "R12");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9", "missing responses", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule